// File: doc/BRIEF.md
# System Bus Tenure Controller

This block sits between a local processor and a shared system bus. It decides when the local side raises a bus request, when it holds mastership, and when it hands the bus back. A request is raised only for two reasons: a local access whose address falls inside the system-bus window, or a pending interrupt acknowledge on the system bus. Local traffic outside that window never disturbs the shared bus.

Once the grant arrives, the block holds the bus busy. It gives the bus up according to a release policy picked by software from six options. The options combine three conditions: another master requesting, a tenure timeout running out, and the bus-clear signal. A release never cuts a transfer short. It is deferred until the local transfer in progress has ended. The tenure timer starts again from zero every time the bus is won.

Top module: `bus_tenure`

## Requirements
- R1: A bus request is raised only when `accValid` and `accHitWin` are both high, or `iackNeed` is high, while idle. An access with `accHitWin` low, or `accHitWin` without `accValid`, leaves `busReq` all zero.
- R2: While requesting, exactly one bit of `busReq` is high, at index `reqLevel` (0 to 3). It appears in the cycle after the need is sampled and drops in the cycle after `busGrant` is sampled.
- R3: `busBusy` goes high in the cycle after a grant is sampled while requesting. The tenure timer restarts from zero on every acquisition, so an earlier, shorter tenure has no effect on the next one.
- R4: Policy code 0 (release on request) releases at the first clock edge in which `otherReq` is sampled high, whatever the timer shows.
- R5: Policy code 1 (timed release) keeps `busBusy` high for exactly `TIMEOUT_CYC` cycles and ignores `otherReq`. Codes 6 and 7 behave the same as code 1.
- R6: Policy code 2 releases when the timeout has expired and `otherReq` is high. With `otherReq` low, the bus is held.
- R7: Policy code 3 releases when the timeout has expired and `busClear` is high. With `busClear` low, the bus is held even if `otherReq` is high.
- R8: Policy code 4 releases on `otherReq` only once the timeout has also expired. A request before expiry does not release the bus.
- R9: Policy code 5 releases on `otherReq` or on timeout expiry, whichever comes first.
- R10: `busBusy` never falls at an edge where `xferBusy` is sampled high. Once `xferBusy` is low and the policy condition holds, it falls after the next edge.
- R11: A synchronous `rst` returns the block to idle, with `busReq` all zero and `busBusy` low, in the cycle after it is sampled. This also applies in the middle of a tenure.
- R12: After a release, a new qualifying need raises a fresh request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| accValid | input | 1 | Local access strobe |
| accHitWin | input | 1 | Access address lies inside the system-bus window |
| iackNeed | input | 1 | A system-bus interrupt acknowledge is pending |
| xferBusy | input | 1 | Local transfer on the system bus is in progress |
| policySel | input | 3 | Release policy code |
| reqLevel | input | LVL_W (2) | Request level toward the arbiter |
| busGrant | input | 1 | Grant from the arbiter on the chosen level |
| otherReq | input | 1 | Another master is requesting the bus |
| busClear | input | 1 | Bus-clear indication from the arbiter |
| busReq | output | NUM_LEVELS (4) | One-hot request lines |
| busBusy | output | 1 | Bus is held by this side |

## Verification
The assertions take for granted that `busGrant` arrives only while a request is up. They also assume that `policySel` stays stable through a tenure, so that a release can be tied to the policy in force when it happened. The stimulus keeps to both assumptions: each grant is a single-cycle pulse given only after the request line has been seen, and the policy, `otherReq` and `busClear` are set before the request is raised. The one exception is the timer-restart test, which changes only `otherReq` mid-tenure under policy 5. Every scenario ends with a reset or a release, so no tenure carries state into the next one.

// File: rtl/bus_tenure_pkg.sv
package bus_tenure_pkg;

  typedef enum logic [2:0] {
    POL_ON_REQ         = 3'd0,
    POL_TIMED          = 3'd1,
    POL_TIMED_IF_REQ   = 3'd2,
    POL_TIMED_IF_CLR   = 3'd3,
    POL_REQ_AFTER_TIME = 3'd4,
    POL_REQ_OR_TIME    = 3'd5
  } relPolicy_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ASK  = 2'd1,
    ST_HELD = 2'd2
  } tenureState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrTimer;
    logic runTimer;
    logic drvReq;
    logic holdBus;
  } ctlStrobe_t;

endpackage

// File: rtl/bus_tenure_dp.sv
module bus_tenure_dp
  import bus_tenure_pkg::*;
#(
  parameter int TIMEOUT_CYC = 8,
  parameter int NUM_LEVELS  = 4,
  localparam int LVL_W = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1,
  localparam int TMR_W = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  ctlStrobe_t            strobe,
  input  logic [2:0]            policySel,
  input  logic                  otherReq,
  input  logic                  busClear,
  input  logic [LVL_W-1:0]      reqLevel,
  output logic [NUM_LEVELS-1:0] busReq,
  output logic                  busBusy,
  output logic                  relWanted
);

  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT_CYC - 1);

  logic [TMR_W-1:0] tmrCount;
  logic             tmrExpired;

  assign tmrExpired = (tmrCount == TMR_LAST);

  // tenure timer: cleared outside ownership, saturates at its last value
  always_ff @(posedge clk) begin
    if (rst || strobe.clrTimer) begin
      tmrCount <= '0;
    end else if (strobe.runTimer && !tmrExpired) begin
      tmrCount <= tmrCount + 1'b1;
    end
  end

  // policy evaluation
  always_comb begin
    case (policySel)
      POL_ON_REQ:         relWanted = otherReq;
      POL_TIMED_IF_REQ:   relWanted = tmrExpired && otherReq;
      POL_TIMED_IF_CLR:   relWanted = tmrExpired && busClear;
      POL_REQ_AFTER_TIME: relWanted = otherReq && tmrExpired;
      POL_REQ_OR_TIME:    relWanted = otherReq || tmrExpired;
      default:            relWanted = tmrExpired;
    endcase
  end

  // one-hot request line decode
  genvar g;
  generate
    for (g = 0; g < NUM_LEVELS; g++) begin : g_lvl
      assign busReq[g] = strobe.drvReq && (reqLevel == LVL_W'(g));
    end
  endgenerate

  assign busBusy = strobe.holdBus;

endmodule

// File: rtl/bus_tenure_fsm.sv
module bus_tenure_fsm
  import bus_tenure_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       needBus,
  input  logic       busGrant,
  input  logic       relWanted,
  input  logic       xferBusy,
  output ctlStrobe_t strobe
);

  tenureState_e state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (needBus)                 stateNext = ST_ASK;
      ST_ASK:  if (busGrant)                stateNext = ST_HELD;
      ST_HELD: if (relWanted && !xferBusy)  stateNext = ST_IDLE;
      default:                              stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    strobe.clrTimer = (state != ST_HELD);
    strobe.runTimer = (state == ST_HELD);
    strobe.drvReq   = (state == ST_ASK);
    strobe.holdBus  = (state == ST_HELD);
  end

endmodule

// File: rtl/bus_tenure.sv
module bus_tenure
  import bus_tenure_pkg::*;
#(
  parameter int TIMEOUT_CYC = 8,
  parameter int NUM_LEVELS  = 4,
  localparam int LVL_W = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  accValid,
  input  logic                  accHitWin,
  input  logic                  iackNeed,
  input  logic                  xferBusy,
  input  logic [2:0]            policySel,
  input  logic [LVL_W-1:0]      reqLevel,
  input  logic                  busGrant,
  input  logic                  otherReq,
  input  logic                  busClear,
  output logic [NUM_LEVELS-1:0] busReq,
  output logic                  busBusy
);

  ctlStrobe_t strobe;
  logic       relWanted;
  logic       needBus;

  assign needBus = (accValid && accHitWin) || iackNeed;

  bus_tenure_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .needBus   (needBus),
    .busGrant  (busGrant),
    .relWanted (relWanted),
    .xferBusy  (xferBusy),
    .strobe    (strobe)
  );

  bus_tenure_dp #(
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .NUM_LEVELS  (NUM_LEVELS)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .policySel (policySel),
    .otherReq  (otherReq),
    .busClear  (busClear),
    .reqLevel  (reqLevel),
    .busReq    (busReq),
    .busBusy   (busBusy),
    .relWanted (relWanted)
  );

endmodule

// File: rtl/bus_tenure_chk.sv
module bus_tenure_chk #(
  parameter int TIMEOUT_CYC = 8,
  parameter int NUM_LEVELS  = 4,
  localparam int CNT_W = $clog2(TIMEOUT_CYC) + 2
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  accValid,
  input logic                  accHitWin,
  input logic                  iackNeed,
  input logic                  xferBusy,
  input logic [2:0]            policySel,
  input logic                  busGrant,
  input logic                  otherReq,
  input logic [NUM_LEVELS-1:0] busReq,
  input logic                  busBusy
);

  logic [CNT_W-1:0] ownCnt;

  // cycles of continuous ownership, saturating
  always_ff @(posedge clk) begin
    if (rst || !busBusy)  ownCnt <= '0;
    else if (ownCnt != '1) ownCnt <= ownCnt + 1'b1;
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (busReq == '0 && !busBusy)); // R11

  AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(|busReq) |-> $past((accValid && accHitWin) || iackNeed)); // R1

  AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(busReq)); // R2

  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (|busReq && busGrant) |=> (busBusy && busReq == '0)); // R3

  AST_NO_MID_XFER: assert property (@(posedge clk) disable iff (rst)
    ($fell(busBusy) && !$past(rst)) |-> !$past(xferBusy)); // R10

  AST_ON_REQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    ($fell(busBusy) && !$past(rst) && $past(policySel) == 3'd0) |-> $past(otherReq)); // R4

  AST_TIMED_FULL: assert property (@(posedge clk) disable iff (rst)
    ($fell(busBusy) && !$past(rst) && $past(policySel) == 3'd1)
      |-> (ownCnt >= CNT_W'(TIMEOUT_CYC))); // R5

endmodule

bind bus_tenure bus_tenure_chk #(
  .TIMEOUT_CYC (TIMEOUT_CYC),
  .NUM_LEVELS  (NUM_LEVELS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .accValid  (accValid),
  .accHitWin (accHitWin),
  .iackNeed  (iackNeed),
  .xferBusy  (xferBusy),
  .policySel (policySel),
  .busGrant  (busGrant),
  .otherReq  (otherReq),
  .busReq    (busReq),
  .busBusy   (busBusy)
);

// File: tb/bus_tenure_tb.sv
module bus_tenure_tb;

  localparam int TO = 8;
  localparam int NL = 4;
  localparam int HOLDS = 63;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       accValid = 1'b0, accHitWin = 1'b0, iackNeed = 1'b0, xferBusy = 1'b0;
  logic [2:0] policySel = 3'd0;
  logic [1:0] reqLevel = 2'd0;
  logic       busGrant = 1'b0, otherReq = 1'b0, busClear = 1'b0;
  logic [NL-1:0] busReq;
  logic       busBusy;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  bus_tenure #(.TIMEOUT_CYC(TO), .NUM_LEVELS(NL)) u_dut (
    .clk(clk), .rst(rst), .accValid(accValid), .accHitWin(accHitWin),
    .iackNeed(iackNeed), .xferBusy(xferBusy), .policySel(policySel),
    .reqLevel(reqLevel), .busGrant(busGrant), .otherReq(otherReq),
    .busClear(busClear), .busReq(busReq), .busBusy(busBusy)
  );

  // {policy[2:0], otherReq, busClear, level[1:0], expected tenure[5:0]}
  localparam int NVEC = 13;
  localparam logic [12:0] VEC [NVEC] = '{
    {3'd0, 1'b1, 1'b0, 2'd0, 6'd1},   // R4
    {3'd0, 1'b0, 1'b0, 2'd1, 6'd63},  // R4
    {3'd1, 1'b1, 1'b0, 2'd2, 6'd8},   // R5
    {3'd1, 1'b0, 1'b0, 2'd3, 6'd8},   // R5
    {3'd2, 1'b1, 1'b0, 2'd0, 6'd8},   // R6
    {3'd2, 1'b0, 1'b1, 2'd1, 6'd63},  // R6
    {3'd3, 1'b0, 1'b1, 2'd2, 6'd8},   // R7
    {3'd3, 1'b1, 1'b0, 2'd3, 6'd63},  // R7
    {3'd4, 1'b1, 1'b0, 2'd0, 6'd8},   // R8
    {3'd4, 1'b0, 1'b0, 2'd1, 6'd63},  // R8
    {3'd5, 1'b1, 1'b0, 2'd2, 6'd1},   // R9
    {3'd5, 1'b0, 1'b0, 2'd3, 6'd8},   // R9
    {3'd7, 1'b0, 1'b0, 2'd0, 6'd8}    // R5
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic doReset();
    rst = 1'b1;
    tick();
    tick();
    rst = 1'b0;
  endtask

  // window access, check request line, grant; returns at first owned cycle
  task automatic acquire(input logic [1:0] lvl);
    reqLevel  = lvl;
    accValid  = 1'b1;
    accHitWin = 1'b1;
    tick();
    accValid  = 1'b0;
    accHitWin = 1'b0;
    chk("R2 request line", int'(busReq), 1 << lvl);
    busGrant = 1'b1;
    tick();
    busGrant = 1'b0;
    chk("R3 busy after grant", int'(busBusy), 1);
    chk("R2 request dropped", int'(busReq), 0);
  endtask

  task automatic measure(output int dur);
    dur = 1;
    while (dur < 24) begin
      tick();
      if (!busBusy) return;
      dur++;
    end
    dur = HOLDS;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int dur;
    tick();
    tick();
    // R11 reset state
    chk("R11 reset busReq", int'(busReq), 0);
    chk("R11 reset busBusy", int'(busBusy), 0);
    rst = 1'b0;

    // table of policy vectors
    for (int i = 0; i < NVEC; i++) begin
      policySel = VEC[i][12:10];
      otherReq  = VEC[i][9];
      busClear  = VEC[i][8];
      acquire(VEC[i][7:6]);
      measure(dur);
      chk($sformatf("R4-9 vec%0d tenure", i), dur, int'(VEC[i][5:0]));
      otherReq = 1'b0;
      busClear = 1'b0;
      doReset();
    end

    // R1: access outside window, and window flag without strobe
    accValid = 1'b1; accHitWin = 1'b0;
    tick(); tick();
    chk("R1 no req outside window", int'(busReq), 0);
    accValid = 1'b0; accHitWin = 1'b1;
    tick(); tick();
    chk("R1 no req without strobe", int'(busReq), 0);
    accHitWin = 1'b0;

    // R1 interrupt acknowledge need, R2 level 3
    reqLevel = 2'd3; iackNeed = 1'b1;
    tick();
    iackNeed = 1'b0;
    chk("R1 iack request", int'(busReq), 8);
    tick();
    chk("R2 request held until grant", int'(busReq), 8);
    doReset();

    // R10 release deferred by transfer in progress
    policySel = 3'd5; otherReq = 1'b1; xferBusy = 1'b1;
    acquire(2'd1);
    repeat (5) tick();
    chk("R10 held during transfer", int'(busBusy), 1);
    xferBusy = 1'b0;
    tick();
    chk("R10 release after transfer", int'(busBusy), 0);
    otherReq = 1'b0;

    // R3 timer restart, R12 re-request after release
    policySel = 3'd5;
    acquire(2'd2);
    repeat (3) tick();
    otherReq = 1'b1;
    tick();
    chk("R9 early release on request", int'(busBusy), 0);
    otherReq = 1'b0;
    policySel = 3'd1;
    acquire(2'd0);                   // R12
    measure(dur);
    chk("R3 timer restarted", dur, TO);

    // R11 reset mid-tenure
    policySel = 3'd0;
    acquire(2'd3);
    rst = 1'b1;
    tick();
    chk("R11 reset drops busy", int'(busBusy), 0);
    chk("R11 reset no request", int'(busReq), 0);
    rst = 1'b0;
    tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule